// File: doc/BRIEF.md
# SPI Register-Access Peripheral with Byte Wait States

This block sits on an SPI bus (mode 0, most significant bit first) and turns each chip-select window into one access to a local register space. The host opens with four bytes: a command byte with a direction flag and a length, then a 24-bit start address. The block then reads or writes between 1 and 64 consecutive bytes, one local request per byte.

The local side may not be able to answer at bus speed. The block can hold off the host in one place only: the last bit of the fourth byte it returns. When that bit is 0 the host keeps clocking filler bytes. The block answers each of them with a byte whose lowest bit shows whether it is ready yet. The first reply with that bit set releases the host, and data moves from the next byte on with no further pauses. All SPI inputs are brought into the system clock domain through a configurable synchronizer.

Top module: `spi_regport`

## Requirements
- R1: In byte 0, bit 7 = 1 selects a read and 0 a write, bits 5:0 hold length−1 (1 to 64 bytes), and bit 6 is ignored. Bytes 1, 2, 3 give the address, high byte first. Data byte k accesses address+k, which wraps modulo 2^24.
- R2: MISO is 0 during header bytes 0 to 2, during bits 7:1 of header byte 3, and during every data byte of a write.
- R3: Bit 0 of header byte 3 is 1 for a write exactly when `reg_ready` is high as that bit is produced. It is always 0 for a read, so every read stalls for at least one byte.
- R4: While stalled, each filler byte is returned as 0x00. The first filler byte in which the block is ready is returned as 0x01, and data starts on the byte after it.
- R5: After release, the transaction never stalls again, and read data bytes come back in consecutive bytes.
- R6: For a write, each received data byte raises one request with `reg_we`=1, the byte on `reg_wdata` and its address on `reg_addr`.
- R7: For a read, the first request is raised once the header is complete, and each further byte is requested while the previous one is shifted out. The returned bytes appear on MISO MSB first and in address order.
- R8: Bytes clocked beyond the declared length raise no request and read back as 0 on MISO.
- R9: Raising chip select abandons the transaction at any point. Bytes not yet complete are dropped, MISO goes to 0, and the next transaction decodes from a fresh header. After reset no request is pending and MISO is 0.
- R10: A request keeps `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` unchanged until `reg_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-peripheral data |
| spi_miso | output | 1 | Peripheral-to-host data |
| reg_req | output | 1 | Local access request, held until accepted |
| reg_we | output | 1 | 1 for a write request, 0 for a read |
| reg_addr | output | 24 | Byte address of the request |
| reg_wdata | output | 8 | Write data byte |
| reg_ready | input | 1 | Accepts a request; with no request pending, signals room for write data |
| reg_rdata | input | 8 | Read data, valid while `reg_ready` accepts a read |

## Verification
The bench builds the block with the default two-stage synchronizer and a serial clock of twelve system clocks. With that ratio, a local side answering in zero to three cycles always has read data back before the next byte. Every length up to 64, write holds of several bytes, and addresses that wrap past 0xFFFFFF therefore fit in one run. Chip select is also raised in the middle of a header, in a stall and in a write's data to check that the transaction is abandoned.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        reg_req,
  output logic        reg_we,
  output logic [23:0] reg_addr,
  output logic [7:0]  reg_wdata,
  input  logic        reg_ready,
  input  logic [7:0]  reg_rdata
);

  localparam logic [1:0] PH_HDR   = 2'd0;
  localparam logic [1:0] PH_STALL = 2'd1;
  localparam logic [1:0] PH_DATA  = 2'd2;
  localparam logic [1:0] PH_DONE  = 2'd3;
  localparam int         LAST     = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   sclk_sy;
  logic [SYNC_STAGES-1:0] cs_sy, mosi_sy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-1:0], spi_sclk};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], spi_cs_n};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], spi_mosi};
    end

  logic cs_idle, rise, fall, mosi_bit;
  assign cs_idle  = cs_sy[LAST];
  assign mosi_bit = mosi_sy[LAST];
  assign rise     = sclk_sy[LAST] & ~sclk_sy[SYNC_STAGES];
  assign fall     = ~sclk_sy[LAST] & sclk_sy[SYNC_STAGES];

  logic [1:0]  phase, hdr_idx;
  logic [2:0]  bit_cnt;
  logic [6:0]  rx_sr, left;
  logic [7:0]  tx_sr, rd_buf, rx_byte;
  logic [23:0] nxt_addr, hdr_addr;
  logic        is_rd, go, rd_have, ready_now, decide;

  assign rx_byte   = {rx_sr, mosi_bit};
  assign hdr_addr  = {nxt_addr[15:0], rx_byte};
  assign ready_now = is_rd ? rd_have : reg_ready;
  assign decide    = (phase == PH_STALL) || (phase == PH_HDR && hdr_idx == 2'd3);
  assign spi_miso  = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= PH_HDR;
      hdr_idx   <= '0;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      left      <= '0;
      tx_sr     <= '0;
      rd_buf    <= '0;
      nxt_addr  <= '0;
      is_rd     <= 1'b0;
      go        <= 1'b0;
      rd_have   <= 1'b0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else if (cs_idle) begin
      phase   <= PH_HDR;
      hdr_idx <= '0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      go      <= 1'b0;
      rd_have <= 1'b0;
      reg_req <= 1'b0;
    end else begin
      if (reg_req && reg_ready) begin
        reg_req <= 1'b0;
        if (!reg_we) begin
          rd_buf  <= reg_rdata;
          rd_have <= 1'b1;
        end
      end

      if (fall && bit_cnt == 3'd7 && decide) begin
        tx_sr <= {ready_now, 7'b0};
        go    <= ready_now;
      end else if (fall && bit_cnt != 3'd0) begin
        tx_sr <= {tx_sr[6:0], 1'b0};
      end

      if (rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sr   <= {rx_sr[5:0], mosi_bit};
        if (bit_cnt == 3'd7) begin
          go    <= 1'b0;
          tx_sr <= '0;
          case (phase)
            PH_HDR: begin
              hdr_idx  <= hdr_idx + 2'd1;
              nxt_addr <= hdr_addr;
              if (hdr_idx == 2'd0) begin
                is_rd <= rx_byte[7];
                left  <= {1'b0, rx_byte[5:0]} + 7'd1;
              end
              if (hdr_idx == 2'd3) begin
                phase <= go ? PH_DATA : PH_STALL;
                if (is_rd) begin
                  reg_req  <= 1'b1;
                  reg_we   <= 1'b0;
                  reg_addr <= hdr_addr;
                  nxt_addr <= hdr_addr + 24'd1;
                end
              end
            end
            PH_STALL, PH_DATA: begin
              if (phase == PH_STALL && go) phase <= PH_DATA;
              if (is_rd && (phase == PH_DATA || go)) begin
                if (left != 7'd0) begin
                  tx_sr   <= rd_buf;
                  rd_have <= 1'b0;
                  left    <= left - 7'd1;
                  if (left > 7'd1) begin
                    reg_req  <= 1'b1;
                    reg_we   <= 1'b0;
                    reg_addr <= nxt_addr;
                    nxt_addr <= nxt_addr + 24'd1;
                  end
                end else begin
                  phase <= PH_DONE;
                end
              end else if (!is_rd && phase == PH_DATA) begin
                reg_req   <= 1'b1;
                reg_we    <= 1'b1;
                reg_addr  <= nxt_addr;
                reg_wdata <= rx_byte;
                nxt_addr  <= nxt_addr + 24'd1;
                left      <= left - 7'd1;
                if (left == 7'd1) phase <= PH_DONE;
              end
            end
            default: ;
          endcase
        end
      end
    end

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_idle,
  input logic [1:0]  phase,
  input logic        go,
  input logic        spi_miso,
  input logic        reg_req,
  input logic        reg_ready,
  input logic        reg_we,
  input logic [23:0] reg_addr,
  input logic [7:0]  reg_wdata
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ready && !cs_idle |=> reg_req || cs_idle); // R10

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ready && !cs_idle |=> cs_idle || ($stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata))); // R10

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !spi_miso); // R9

  AST_NO_RESTALL: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd2 |=> phase != 2'd1); // R5

  AST_STALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd1 |-> spi_miso == go); // R4

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 && $past(phase) == 2'd3 |-> !$rose(reg_req)); // R8

endmodule

bind spi_regport spi_regport_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .phase(phase), .go(go),
  .spi_miso(spi_miso), .reg_req(reg_req), .reg_ready(reg_ready), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/test_spi_regport.sv
module test_spi_regport;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 6;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic reg_req, reg_we, reg_ready = 1'b0;
  logic [23:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata = '0;

  int n_checks = 0, n_err = 0, n_req = 0;
  logic [23:0] last_addr = '0;
  logic accept_lvl = 1'b1;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  bit serving = 0;
  int wait_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regport i_spi_regport (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] seed_byte(int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [7:0] idx(logic [23:0] a, int k);
    logic [23:0] s;
    s = a + 24'(k);
    return s[7:0];
  endfunction

  // local register space model
  always @(negedge clk) begin
    if (reg_req) begin
      if (!serving) begin
        serving  = 1;
        wait_cnt = $urandom_range(0, 3);
        n_req++;
        last_addr = reg_addr;
      end
      if (wait_cnt == 0) begin
        reg_ready = 1'b1;
        if (reg_we) mem[reg_addr[7:0]] = reg_wdata;
        else reg_rdata = mem[reg_addr[7:0]];
        serving = 0;
      end else begin
        wait_cnt--;
        reg_ready = 1'b0;
      end
    end else begin
      serving   = 0;
      reg_ready = accept_lvl;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF_SCK) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (HALF_SCK) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_begin;
    n_req = 0;
    cs_n = 1'b0;
    repeat (2*HALF_SCK) @(negedge clk);
  endtask

  task automatic cs_end;
    repeat (HALF_SCK) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF_SCK) @(negedge clk);
  endtask

  task automatic send_header(input bit rd, input int size, input logic [23:0] addr, input bit b6,
                             output logic [7:0] last);
    logic [7:0] rx;
    spi_byte({rd, b6, 6'(size - 1)}, rx);
    check(rx == 8'h00, "R2", "header byte 0 MISO", int'(rx), 0);
    spi_byte(addr[23:16], rx);
    check(rx == 8'h00, "R2", "header byte 1 MISO", int'(rx), 0);
    spi_byte(addr[15:8], rx);
    check(rx == 8'h00, "R2", "header byte 2 MISO", int'(rx), 0);
    spi_byte(addr[7:0], last);
    check(last[7:1] == 7'd0, "R2", "header byte 3 upper bits", int'(last), 0);
  endtask

  task automatic run_txn(input bit rd, input int size, input logic [23:0] addr,
                         input int hold, input int extra, input bit b6);
    logic [7:0] rx, d;
    int stalls;
    bit rel;
    accept_lvl = (hold == 0);
    cs_begin;
    send_header(rd, size, addr, b6, rx);
    if (rd) check(rx[0] == 1'b0, "R3", "read ready bit in byte 3", int'(rx[0]), 0);
    else    check(rx[0] == (hold == 0), "R3", "write ready bit in byte 3", int'(rx[0]), int'(hold == 0));
    rel = rx[0];
    stalls = 0;
    while (!rel && stalls < 40) begin
      if (!rd && stalls + 1 == hold) accept_lvl = 1'b1;
      spi_byte(8'h00, rx);
      stalls++;
      check(rx[7:1] == 7'd0, "R4", "stall byte upper bits", int'(rx), int'(rx[0]));
      rel = rx[0];
    end
    check(rel, "R4", "stall released", int'(rel), 1);
    if (rd) check(stalls >= 1, "R3", "read stall bytes", stalls, 1);
    else    check(stalls == hold, "R4", "write stall bytes", stalls, hold);
    for (int i = 0; i < size; i++) begin
      if (rd) begin
        spi_byte(8'h00, rx);
        check(rx == exp_mem[idx(addr, i)], "R7", "read data byte", int'(rx), int'(exp_mem[idx(addr, i)]));
      end else begin
        d = 8'($urandom);
        spi_byte(d, rx);
        check(rx == 8'h00, "R2", "MISO during write data", int'(rx), 0);
        exp_mem[idx(addr, i)] = d;
      end
    end
    for (int e = 0; e < extra; e++) begin
      spi_byte(8'hA5, rx);
      check(rx == 8'h00, "R8", "MISO after last byte", int'(rx), 0);
    end
    cs_end;
    check(n_req == size, "R8", "request count", n_req, size);
    check(last_addr == addr + 24'(size - 1), "R1", "final address", int'(last_addr), int'(addr + 24'(size - 1)));
    if (!rd)
      for (int i = 0; i < size + extra && i < 256; i++)
        check(mem[idx(addr, i)] == exp_mem[idx(addr, i)], "R6", "written byte",
              int'(mem[idx(addr, i)]), int'(exp_mem[idx(addr, i)]));
  endtask

  initial begin
    logic [7:0] rx;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) begin
      mem[i] = seed_byte(i);
      exp_mem[i] = seed_byte(i);
    end
    repeat (5) @(negedge clk);
    check(miso == 1'b0, "R9", "MISO in reset", int'(miso), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(reg_req == 1'b0 && miso == 1'b0, "R9", "idle after reset", int'({reg_req, miso}), 0);

    // directed cases
    run_txn(1'b0, 1, 24'h000010, 0, 0, 1'b0);
    run_txn(1'b1, 1, 24'h000010, 0, 0, 1'b0);
    run_txn(1'b0, 4, 24'hAABBCC, 3, 0, 1'b0);
    run_txn(1'b1, 4, 24'hAABBCC, 0, 2, 1'b1);     // R1 bit 6 ignored, R8 extra bytes
    run_txn(1'b0, 64, 24'h123400, 2, 2, 1'b1);
    run_txn(1'b1, 64, 24'h123400, 0, 1, 1'b0);
    run_txn(1'b0, 3, 24'hFFFFFE, 0, 1, 1'b0);     // R1 address wrap
    run_txn(1'b1, 3, 24'hFFFFFE, 0, 0, 1'b0);

    // R9: abort inside the header
    cs_begin;
    spi_byte(8'h03, rx);
    spi_byte(8'h00, rx);
    cs_end;
    check(n_req == 0, "R9", "requests after header abort", n_req, 0);

    // R9: abort during a stall
    accept_lvl = 1'b0;
    cs_begin;
    send_header(1'b0, 2, 24'h000040, 1'b0, rx);
    spi_byte(8'h00, rx);
    check(rx == 8'h00, "R4", "stall byte while busy", int'(rx), 0);
    cs_end;
    check(n_req == 0, "R9", "requests after stall abort", n_req, 0);

    // R9: abort inside write data
    accept_lvl = 1'b1;
    cs_begin;
    send_header(1'b0, 4, 24'h000050, 1'b0, rx);
    spi_byte(8'h5A, rx);
    spi_byte(8'hC3, rx);
    cs_end;
    exp_mem[8'h50] = 8'h5A;
    exp_mem[8'h51] = 8'hC3;
    check(n_req == 2, "R9", "requests after data abort", n_req, 2);
    for (int i = 0; i < 4; i++)
      check(mem[8'h50 + i] == exp_mem[8'h50 + i], "R9", "memory after data abort",
            int'(mem[8'h50 + i]), int'(exp_mem[8'h50 + i]));
    run_txn(1'b1, 4, 24'h000050, 0, 0, 1'b0);

    // constrained random mix
    for (int t = 0; t < 18; t++) begin
      bit rd;
      rd = 1'($urandom);
      run_txn(rd, $urandom_range(1, 64), 24'($urandom), rd ? 0 : $urandom_range(0, 3),
              $urandom_range(0, 2), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog (R1..R10 run): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule